// File: doc/BRIEF.md
# Macro Follow-State Sequencer

This block is the bus-transaction engine of a small processor's control unit. When the instruction decoder meets an instruction that needs more than one cycle of memory traffic, it hands the sequencer a start index, an address and up to two data bytes. The sequencer then walks a small table of follow-state codes, one entry at a time. Each code either runs a one-byte memory read or write, or adjusts the working address. The walk stops when the table yields an ending code, and a one-cycle done pulse hands control back to instruction fetch.

Reads gather up to two bytes into a 16-bit result register, in the low or the high half. Writes take their bytes from a data register that is captured at start. The address register can step forward by one, or be reset to its value at start. That reset lets one macro read a word and then write a new word back to the same place, which is the exchange-with-stack pattern.

Top module: `macro_seq`

## Requirements
- R1: After reset, and until a macro is started, `rd_o`, `wr_o` and `done_o` are 0, `addr_o` and `dout_o` are 0, and `rdata_o` is 0.
- R2: The table has 16 entries of 4-bit codes: 0 end, 1 read-low, 2 read-high, 3 write-low, 4 write-high, 5 address step, 6 address reload, 7 fetch. Its contents by index are: 0 read-low, 1 step, 2 read-high, 3 end, 4 write-low, 5 step, 6 write-high, 7 end, 8 read-low, 9 step, 10 read-high, 11 reload, 12 write-low, 13 step, 14 write-high, 15 fetch.
- R3: A read takes two states. In the first, `rd_o` is 1 for one cycle with the working address on `addr_o`. In the second, `rd_o` is 0, `addr_o` is held, and `rdata_i` is captured into bits [7:0] (read-low) or [15:8] (read-high) of `rdata_o`. `rdata_o` is cleared when a start is accepted.
- R4: A write takes four states. In the first, the address and the byte are driven with `wr_o` at 0. In the second, `wr_o` is 1. In the third, `wr_o` is 0 and the address and byte are held. In the fourth, the bus is released. Write-low sends `wdata_i[7:0]` and write-high sends `wdata_i[15:8]`, as captured at start.
- R5: Each table entry takes one dispatch cycle; reads add 2 cycles and writes add 4. When `start_i` is sampled at an edge, `done_o` rises exactly N edges later, where N is the sum of these cycle counts over the entries the chain visits.
- R6: The address step adds 1 modulo 2^16. The address reload restores the address given at start. Reads and writes use the current working address.
- R7: Code 0 or 7 ends the chain, and codes 8 to 15 also end it. On ending, `done_o` is 1 for exactly one cycle, and the block accepts a new start in that cycle.
- R8: A start request made while a chain is active is ignored. The chain completes with its original index, address and data, and no second chain follows.
- R9: `rd_o` and `wr_o` are never 1 together. `addr_o` and `dout_o` are 0 whenever no read or write is in progress, including the cycle of `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request from decode |
| idx_i | input | 4 | Table start index |
| addr_i | input | 16 | Address mailbox value |
| wdata_i | input | 16 | Write data mailbox (low byte, high byte) |
| rdata_i | input | 8 | Read data bus |
| addr_o | output | 16 | Address bus |
| rd_o | output | 1 | Memory read strobe |
| wr_o | output | 1 | Memory write strobe |
| dout_o | output | 8 | Write data bus |
| rdata_o | output | 16 | Gathered read data |
| done_o | output | 1 | One-cycle chain-complete pulse |

## Verification
The assertions check the local bus rules on every cycle: the strobes never overlap, each strobe lasts one cycle, the address and write byte are held around each strobe, and done lasts one cycle with the bus idle. The bench covers what depends on the table and on ordering. It sweeps every start index across several addresses, including the wrap at the top of the address space. For each run it checks the exact cycle count to done, the order and addresses of reads and writes, the written bytes, the gathered word, and that a start request made mid-chain is ignored.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_END   = 4'd0,
    OP_RDL   = 4'd1,
    OP_RDH   = 4'd2,
    OP_WRL   = 4'd3,
    OP_WRH   = 4'd4,
    OP_INC   = 4'd5,
    OP_RLD   = 4'd6,
    OP_FETCH = 4'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DISP,
    ST_RD1,
    ST_RD2,
    ST_WR1,
    ST_WR2,
    ST_WR3,
    ST_WR4
  } st_e;

  // macro table: word load at 0, word store at 4, exchange at 8
  function automatic logic [OP_W-1:0] rom_entry(input int unsigned i);
    case (i)
      0:  return OP_RDL;
      1:  return OP_INC;
      2:  return OP_RDH;
      3:  return OP_END;
      4:  return OP_WRL;
      5:  return OP_INC;
      6:  return OP_WRH;
      7:  return OP_END;
      8:  return OP_RDL;
      9:  return OP_INC;
      10: return OP_RDH;
      11: return OP_RLD;
      12: return OP_WRL;
      13: return OP_INC;
      14: return OP_WRH;
      15: return OP_FETCH;
      default: return OP_END;
    endcase
  endfunction

endpackage

// File: rtl/macro_rom.sv
module macro_rom
  import macro_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [OP_W-1:0]  op_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [OP_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign table_q[g] = rom_entry(g);
  end

  assign op_o = table_q[idx_i];
endmodule

// File: rtl/macro_addr.sv
module macro_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  input  logic              reload_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= load_val_i;
      cur_q  <= load_val_i;
    end else if (reload_i) begin
      cur_q  <= base_q;
    end else if (inc_i) begin
      cur_q  <= cur_q + 1'b1;
    end
  end

  assign addr_o = cur_q;
endmodule

// File: rtl/macro_gather.sv
module macro_gather #(
  parameter int BYTE_W = 8,
  parameter int NLANE  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    cap_i,
  input  logic [NLANE-1:0]        lane_i,
  input  logic [BYTE_W-1:0]       byte_i,
  output logic [NLANE*BYTE_W-1:0] word_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 lane_q <= '0;
      else if (clr_i)              lane_q <= '0;
      else if (cap_i && lane_i[g]) lane_q <= byte_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import macro_seq_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0]   rdata_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                rd_o,
  output logic                wr_o,
  output logic [BYTE_W-1:0]   dout_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                done_o
);
  localparam int WORD_W = 2 * BYTE_W;

  st_e               st_q;
  logic [IDX_W-1:0]  ptr_q;
  logic              hi_q;
  logic              done_q;
  logic [WORD_W-1:0] wdat_q;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] cur_addr;
  logic              accept, disp, step, reload, cap, addr_act, data_act;

  macro_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i (ptr_q),
    .op_o  (op)
  );

  assign accept = (st_q == ST_IDLE) && start_i;
  assign disp   = (st_q == ST_DISP);
  assign step   = disp && (op == OP_INC);
  assign reload = disp && (op == OP_RLD);
  assign cap    = (st_q == ST_RD2);

  macro_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (addr_i),
    .inc_i      (step),
    .reload_i   (reload),
    .addr_o     (cur_addr)
  );

  macro_gather #(.BYTE_W(BYTE_W), .NLANE(2)) u_gather (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cap_i  (cap),
    .lane_i ({hi_q, ~hi_q}),
    .byte_i (rdata_i),
    .word_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      hi_q   <= 1'b0;
      done_q <= 1'b0;
      wdat_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          ptr_q  <= idx_i;
          wdat_q <= wdata_i;
          st_q   <= ST_DISP;
        end
        ST_DISP: begin
          ptr_q <= ptr_q + 1'b1;
          case (op)
            OP_RDL: begin hi_q <= 1'b0; st_q <= ST_RD1; end
            OP_RDH: begin hi_q <= 1'b1; st_q <= ST_RD1; end
            OP_WRL: begin hi_q <= 1'b0; st_q <= ST_WR1; end
            OP_WRH: begin hi_q <= 1'b1; st_q <= ST_WR1; end
            OP_INC, OP_RLD: st_q <= ST_DISP;
            default: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
        ST_RD1: st_q <= ST_RD2;
        ST_RD2: st_q <= ST_DISP;
        ST_WR1: st_q <= ST_WR2;
        ST_WR2: st_q <= ST_WR3;
        ST_WR3: st_q <= ST_WR4;
        ST_WR4: st_q <= ST_DISP;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign data_act = (st_q == ST_WR1) || (st_q == ST_WR2) || (st_q == ST_WR3);
  assign addr_act = data_act || (st_q == ST_RD1) || (st_q == ST_RD2);

  assign addr_o = addr_act ? cur_addr : '0;
  assign dout_o = data_act ? wdat_q[(hi_q ? BYTE_W : 0) +: BYTE_W] : '0;
  assign rd_o   = (st_q == ST_RD1);
  assign wr_o   = (st_q == ST_WR2);
  assign done_o = done_q;
endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_o,
  input logic              wr_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BYTE_W-1:0] dout_o
);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R3
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o);

  // R3
  rd_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> $stable(addr_o));

  // R4
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  // R4
  wr_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($stable(addr_o) && $stable(dout_o)));

  // R4
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> ($stable(addr_o) && $stable(dout_o)));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_o && !wr_o && addr_o == '0 && dout_o == '0));
endmodule

bind macro_seq macro_seq_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_o   (rd_o),
  .wr_o   (wr_o),
  .done_o (done_o),
  .addr_o (addr_o),
  .dout_o (dout_o)
);

// File: tb/macro_seq_test.sv
`timescale 1ns/1ps
module macro_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  idx_i = '0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  rdata_i;
  logic [15:0] addr_o;
  logic        rd_o, wr_o, done_o;
  logic [7:0]  dout_o;
  logic [15:0] rdata_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  macro_seq uut (
    .clk_i, .rst_ni, .start_i, .idx_i, .addr_i, .wdata_i, .rdata_i,
    .addr_o, .rd_o, .wr_o, .dout_o, .rdata_o, .done_o
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign rdata_i = mem_f(addr_o);

  // table as given in R2
  function automatic logic [3:0] tb_rom(input int i);
    case (i & 15)
      0: return 4'd1;  1: return 4'd5;  2: return 4'd2;  3: return 4'd0;
      4: return 4'd3;  5: return 4'd5;  6: return 4'd4;  7: return 4'd0;
      8: return 4'd1;  9: return 4'd5;  10: return 4'd2; 11: return 4'd6;
      12: return 4'd3; 13: return 4'd5; 14: return 4'd4; default: return 4'd7;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_macro(input int idx, input logic [15:0] a, input logic [15:0] wd, input bit extra);
    logic [15:0] cur, base, exp_rd;
    logic [15:0] e_ra [8];
    logic [15:0] e_wa [8];
    logic [7:0]  e_wd [8];
    logic [15:0] g_ra [8];
    logic [15:0] g_wa [8];
    logic [7:0]  g_wd [8];
    int nr, nw, gr, gw, len, p, cyc;
    bit fin;
    logic [3:0] op;
    cur = a; base = a; exp_rd = '0; nr = 0; nw = 0; len = 0; p = idx; fin = 0;
    while (!fin) begin
      op = tb_rom(p); p++; len++;
      case (op)
        4'd1: begin e_ra[nr] = cur; nr++; exp_rd[7:0] = mem_f(cur); len += 2; end
        4'd2: begin e_ra[nr] = cur; nr++; exp_rd[15:8] = mem_f(cur); len += 2; end
        4'd3: begin e_wa[nw] = cur; e_wd[nw] = wd[7:0]; nw++; len += 4; end
        4'd4: begin e_wa[nw] = cur; e_wd[nw] = wd[15:8]; nw++; len += 4; end
        4'd5: cur = cur + 16'd1;
        4'd6: cur = base;
        default: fin = 1;
      endcase
    end
    @(negedge clk_i);
    start_i = 1'b1; idx_i = 4'(idx); addr_i = a; wdata_i = wd;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 0; gr = 0; gw = 0;
    while (!done_o && cyc < 100) begin
      chk(!(rd_o && wr_o), "R9 strobe overlap", {rd_o, wr_o}, 0);
      if (rd_o && gr < 8) begin g_ra[gr] = addr_o; gr++; end
      if (wr_o && gw < 8) begin g_wa[gw] = addr_o; g_wd[gw] = dout_o; gw++; end
      if (extra && cyc == 2) begin
        start_i = 1'b1; idx_i = 4'(idx + 3); addr_i = ~a; wdata_i = ~wd;
      end
      if (extra && cyc == 3) start_i = 1'b0;
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc == len, "R5 (R2 table) cycles to done", cyc, len);
    chk(rdata_o == exp_rd, "R3 gathered data", rdata_o, exp_rd);
    chk(gr == nr, "R3 read count", gr, nr);
    chk(gw == nw, "R4 write count", gw, nw);
    for (int k = 0; k < nr && k < gr; k++)
      chk(g_ra[k] == e_ra[k], "R6 read address", g_ra[k], e_ra[k]);
    for (int k = 0; k < nw && k < gw; k++) begin
      chk(g_wa[k] == e_wa[k], "R6 write address", g_wa[k], e_wa[k]);
      chk(g_wd[k] == e_wd[k], "R4 write byte", g_wd[k], e_wd[k]);
    end
    chk(addr_o == 16'd0 && dout_o == 8'd0, "R9 bus idle at done", {addr_o, dout_o}, 0);
    @(negedge clk_i);
    chk(!done_o, "R7 done one cycle", done_o, 0);
    if (extra) begin
      int act;
      act = 0;
      for (int k = 0; k < 30; k++) begin
        if (rd_o || wr_o || done_o) act++;
        @(negedge clk_i);
      end
      chk(act == 0, "R8 start ignored while active", act, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [5];
    addrs[0] = 16'h0000; addrs[1] = 16'h1234; addrs[2] = 16'h00FF;
    addrs[3] = 16'hFFFF; addrs[4] = 16'h7FFE;
    repeat (3) @(negedge clk_i);
    chk(!rd_o && !wr_o && !done_o && addr_o == 0 && dout_o == 0 && rdata_o == 0,
        "R1 reset state", {rd_o, wr_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!rd_o && !wr_o && !done_o && rdata_o == 0, "R1 idle after reset", rdata_o, 0);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 5; j++)
        run_macro(i, addrs[j], addrs[j] ^ 16'h3C96 ^ 16'(i * 257), 1'b0);
    run_macro(4, 16'hFFFF, 16'hBEEF, 1'b1);
    run_macro(8, 16'h2000, 16'hCAFE, 1'b1);
    run_macro(3, 16'h4444, 16'h1111, 1'b1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule